// File: doc/BRIEF.md
# Watchdog and Interval Timer with Keyed Control

This block is a timer peripheral that serves either as a system watchdog or as a periodic interval timer. Software sets it up through one 16-bit control word on a simple word-wide register bus. Every write must carry a key byte in its upper half. A write without the key is treated as a fault, and the block then requests a system reset. Reads return a fixed marker byte in the upper half, so the live key never appears on the bus.

The counter advances once for each enable pulse from one of two clock-enable sources. When it reaches the selected terminal count, it wraps. In interval mode, the wrap produces a one-cycle pulse that sets the interval flag. In watchdog mode, the wrap latches a reset request that holds until the system reset arrives.

The block also watches an external pin. In one mode the pin is an active-low reset input. In the other mode it is a non-maskable interrupt input that reacts to the edge chosen by software. The pin passes through a two-flop synchronizer before it is used.

Top module: `wdg_interval_timer`

## Requirements
- R1: A write to word address 0x120 whose upper byte is not 0x5A latches the reset request at that clock edge, and its lower byte is still stored as the control byte.
- R2: A read of address 0x120 returns 0x69 in bits 15:8 and the stored control byte in bits 7:0. At any other address the read data is 0 and a write has no effect, not even a reset request.
- R3: Writing control bit 3 as 1 zeroes the counter at that write's edge. The bit is never stored, so it always reads back 0.
- R4: While control bit 7 (hold) is 1, the counter does not advance and no expiry occurs, whatever the enable inputs do.
- R5: Control bit 2 selects the counting source: 1 counts `aux_tick` pulses, 0 counts `sub_tick` pulses. Pulses on the unselected input are ignored.
- R6: Control bits 1:0 set the terminal count: 00 gives 32768, 01 gives 8192, 10 gives 512, 11 gives 64. When the incremented count is at or above the terminal count, an expiry occurs and the counter keeps that value modulo the terminal count, so the count carries over when the interval is shortened.
- R7: On expiry, with control bit 4 = 1 (interval mode), `ivl_flag_set` pulses high for one cycle; it drives bit 0 of interrupt-flag byte 1. With bit 4 = 0 (watchdog mode), the reset request is latched instead and `ivl_flag_set` stays low. Either result is visible right after the clock edge of the expiring tick.
- R8: With control bit 5 = 0, the pin is an active-low reset input. `rst_req` is high from the second edge after the pin goes low until the second edge after it returns high, and nothing is latched.
- R9: With control bit 5 = 1, the pin is an interrupt input and never requests reset. `nmi_flag_set` pulses for one cycle at the third edge after a pin edge of the selected polarity: falling when bit 6 = 1, rising when bit 6 = 0. It drives bit 4 of interrupt-flag byte 1.
- R10: The synchronous reset `rst` clears the control byte, the counter and the latched reset request. The block therefore restarts in watchdog mode with the 32768 terminal count, counting `sub_tick`.
- R11: Once latched, the reset request stays asserted through later valid writes until `rst` is applied.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high system reset |
| bus_addr | input | 16 | Register bus word address |
| bus_wdata | input | 16 | Register bus write data (key in 15:8, control in 7:0) |
| bus_we | input | 1 | Write strobe, one cycle per write |
| bus_rdata | output | 16 | Read data for the current address (combinational) |
| aux_tick | input | 1 | Auxiliary clock-enable pulse |
| sub_tick | input | 1 | Subsystem clock-enable pulse |
| ext_pin | input | 1 | Asynchronous external reset / interrupt pin |
| rst_req | output | 1 | System reset request |
| ivl_flag_set | output | 1 | One-cycle pulse that sets the interval flag |
| nmi_flag_set | output | 1 | One-cycle pulse that sets the NMI flag |

## Verification
Each result has a fixed delay after its stimulus:
- Read data is combinational and is due in the same cycle the address is presented.
- A write, a key fault, a counter clear and an expiring tick all take effect at the edge that samples them.
- A pin level change reaches `rst_req` two edges later.
- A pin edge reaches `nmi_flag_set` three edges later.

The bench stamps each expected value with the absolute cycle in which it is due, counting from the edge after which the stimulus was driven. A monitor compares each value at the falling edge of exactly that cycle. Cycles just before and just after each expiry and pin event are also checked, so a result that arrives one cycle early or late is caught.

// File: rtl/wdg_pkg.sv
package wdg_pkg;

    // Terminal counts are powers of two; the exponents fix the four intervals.
    localparam int TC_LOG2_LONG  = 15;
    localparam int TC_LOG2_MID   = 13;
    localparam int TC_LOG2_SHORT = 9;
    localparam int TC_LOG2_MIN   = 6;
    localparam int CNT_W         = TC_LOG2_LONG + 1;

    typedef logic [CNT_W-1:0] cnt_t;

    typedef enum logic [1:0] {
        TSEL_LONG  = 2'b00,
        TSEL_MID   = 2'b01,
        TSEL_SHORT = 2'b10,
        TSEL_MIN   = 2'b11
    } tsel_e;

    // Field order is software-visible: bit 7 down to bit 0.
    typedef struct packed {
        logic  hold;      // 7
        logic  nmi_fall;  // 6
        logic  pin_nmi;   // 5
        logic  interval;  // 4
        logic  clr;       // 3, never stored
        logic  aux_sel;   // 2
        tsel_e tsel;      // 1:0
    } ctrl_t;

    function automatic cnt_t term_count(input tsel_e sel);
        cnt_t one;
        one = cnt_t'(1);
        case (sel)
            TSEL_LONG:  return one << TC_LOG2_LONG;
            TSEL_MID:   return one << TC_LOG2_MID;
            TSEL_SHORT: return one << TC_LOG2_SHORT;
            default:    return one << TC_LOG2_MIN;
        endcase
    endfunction

endpackage

// File: rtl/wdg_ctrl_reg.sv
module wdg_ctrl_reg
    import wdg_pkg::*;
#(
    parameter int          ADDR_W    = 16,
    parameter logic [15:0] BASE_ADDR = 16'h0120,
    parameter logic [7:0]  WRITE_KEY = 8'h5A,
    parameter logic [7:0]  READ_KEY  = 8'h69
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [15:0]       bus_wdata,
    input  logic              bus_we,
    output logic [15:0]       bus_rdata,
    output ctrl_t             ctrl,
    output logic              clr_strobe,
    output logic              key_fault
);

    logic  hit;
    ctrl_t wr_val;

    always_comb begin
        hit        = (bus_addr == BASE_ADDR[ADDR_W-1:0]);
        wr_val     = ctrl_t'(bus_wdata[7:0]);
        wr_val.clr = 1'b0;
        clr_strobe = bus_we && hit && bus_wdata[3];
        key_fault  = bus_we && hit && (bus_wdata[15:8] != WRITE_KEY);
        bus_rdata  = hit ? {READ_KEY, ctrl} : 16'h0000;
    end

    always_ff @(posedge clk) begin
        if (rst)
            ctrl <= '0;
        else if (bus_we && hit)
            ctrl <= wr_val;
    end

    assert_clr_reads_zero_R3: assert property (@(posedge clk) disable iff (rst)
        (bus_we && hit) |=> (bus_rdata[3] == 1'b0));

endmodule

// File: rtl/wdg_counter.sv
module wdg_counter
    import wdg_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  ctrl_t ctrl,
    input  logic  clr,
    input  logic  aux_tick,
    input  logic  sub_tick,
    output logic  wd_fire,
    output logic  ivl_set
);

    cnt_t cnt, nxt, term;
    logic tick, roll;

    always_comb begin
        tick    = ctrl.aux_sel ? aux_tick : sub_tick;
        term    = term_count(ctrl.tsel);
        nxt     = cnt + cnt_t'(1);
        roll    = tick && !ctrl.hold && !clr && (nxt >= term);
        wd_fire = roll && !ctrl.interval;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt     <= '0;
            ivl_set <= 1'b0;
        end else begin
            ivl_set <= roll && ctrl.interval;
            if (clr)
                cnt <= '0;
            else if (tick && !ctrl.hold)
                cnt <= roll ? (nxt & (term - cnt_t'(1))) : nxt;
        end
    end

    assert_hold_freezes_R4: assert property (@(posedge clk) disable iff (rst)
        (ctrl.hold && !clr) |=> (cnt == $past(cnt)));

    assert_clear_zeroes_R3: assert property (@(posedge clk) disable iff (rst)
        clr |=> (cnt == '0));

    assert_ivl_single_R7: assert property (@(posedge clk) disable iff (rst)
        ivl_set |=> (!ivl_set || term == cnt_t'(1)));

endmodule

// File: rtl/wdg_pin_unit.sv
module wdg_pin_unit
    import wdg_pkg::*;
#(
    parameter int SYNC_N = 2
) (
    input  logic  clk,
    input  logic  rst,
    input  ctrl_t ctrl,
    input  logic  ext_pin,
    output logic  pin_rst,
    output logic  nmi_set
);

    logic [SYNC_N-1:0] stage;
    logic              synced, last, fell, rose;

    always_comb begin
        synced  = stage[SYNC_N-1];
        fell    = last && !synced;
        rose    = !last && synced;
        pin_rst = !ctrl.pin_nmi && !synced;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            stage   <= '1;
            last    <= 1'b1;
            nmi_set <= 1'b0;
        end else begin
            stage   <= {stage[SYNC_N-2:0], ext_pin};
            last    <= synced;
            nmi_set <= ctrl.pin_nmi && (ctrl.nmi_fall ? fell : rose);
        end
    end

    assert_nmi_single_R9: assert property (@(posedge clk) disable iff (rst)
        nmi_set |=> !nmi_set);

    assert_nmi_mode_only_R9: assert property (@(posedge clk) disable iff (rst)
        nmi_set |-> $past(ctrl.pin_nmi));

endmodule

// File: rtl/wdg_interval_timer.sv
module wdg_interval_timer
    import wdg_pkg::*;
#(
    parameter int          ADDR_W    = 16,
    parameter logic [15:0] BASE_ADDR = 16'h0120,
    parameter logic [7:0]  WRITE_KEY = 8'h5A,
    parameter logic [7:0]  READ_KEY  = 8'h69,
    parameter int          SYNC_N    = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [15:0]       bus_wdata,
    input  logic              bus_we,
    output logic [15:0]       bus_rdata,
    input  logic              aux_tick,
    input  logic              sub_tick,
    input  logic              ext_pin,
    output logic              rst_req,
    output logic              ivl_flag_set,
    output logic              nmi_flag_set
);

    ctrl_t ctrl;
    logic  clr_strobe, key_fault, wd_fire, pin_rst, rst_latched;

    wdg_ctrl_reg #(
        .ADDR_W(ADDR_W), .BASE_ADDR(BASE_ADDR),
        .WRITE_KEY(WRITE_KEY), .READ_KEY(READ_KEY)
    ) u_ctrl (
        .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_we(bus_we), .bus_rdata(bus_rdata), .ctrl(ctrl),
        .clr_strobe(clr_strobe), .key_fault(key_fault)
    );

    wdg_counter u_cnt (
        .clk(clk), .rst(rst), .ctrl(ctrl), .clr(clr_strobe),
        .aux_tick(aux_tick), .sub_tick(sub_tick),
        .wd_fire(wd_fire), .ivl_set(ivl_flag_set)
    );

    wdg_pin_unit #(.SYNC_N(SYNC_N)) u_pin (
        .clk(clk), .rst(rst), .ctrl(ctrl), .ext_pin(ext_pin),
        .pin_rst(pin_rst), .nmi_set(nmi_flag_set)
    );

    always_ff @(posedge clk) begin
        if (rst)
            rst_latched <= 1'b0;
        else if (key_fault || wd_fire)
            rst_latched <= 1'b1;
    end

    assign rst_req = rst_latched || pin_rst;

    assert_key_fault_resets_R1: assert property (@(posedge clk) disable iff (rst)
        key_fault |=> rst_req);

    assert_latch_sticky_R11: assert property (@(posedge clk) disable iff (rst)
        rst_latched |=> rst_latched);

    assert_ivl_needs_mode_R7: assert property (@(posedge clk) disable iff (rst)
        ivl_flag_set |-> $past(ctrl.interval));

    assert_watchdog_resets_R7: assert property (@(posedge clk) disable iff (rst)
        wd_fire |=> rst_req);

endmodule

// File: tb/tb_wdg_interval_timer.sv
module tb_wdg_interval_timer;
    localparam int CLK_PERIOD = 10;
    localparam int F_RST = 0, F_IVL = 1, F_NMI = 2, F_RD = 3;
    localparam logic [15:0] A_CTL = 16'h0120;

    logic        clk = 1'b0, rst = 1'b1;
    logic [15:0] bus_addr = A_CTL, bus_wdata = 16'h0;
    logic        bus_we = 1'b0, aux_tick = 1'b0, sub_tick = 1'b0, ext_pin = 1'b1;
    logic [15:0] bus_rdata;
    logic        rst_req, ivl_flag_set, nmi_flag_set;

    wdg_interval_timer dut (
        .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_we(bus_we), .bus_rdata(bus_rdata), .aux_tick(aux_tick),
        .sub_tick(sub_tick), .ext_pin(ext_pin), .rst_req(rst_req),
        .ivl_flag_set(ivl_flag_set), .nmi_flag_set(nmi_flag_set)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    int cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    typedef struct {
        int          due;
        int          field;
        logic [15:0] val;
        string       tag;
    } exp_t;

    exp_t q[$];
    exp_t keep_q[$];
    int   total = 0, bad = 0;
    bit   done = 0;

    // Scoreboard monitor: compares every item due in this cycle.
    always @(negedge clk) begin
        logic [15:0] act;
        keep_q = {};
        foreach (q[i]) begin
            if (q[i].due == cyc) begin
                case (q[i].field)
                    F_RST:   act = {15'd0, rst_req};
                    F_IVL:   act = {15'd0, ivl_flag_set};
                    F_NMI:   act = {15'd0, nmi_flag_set};
                    default: act = bus_rdata;
                endcase
                total++;
                if (act !== q[i].val) begin
                    bad++;
                    $display("FAIL %s field=%0d cyc=%0d actual=%h expected=%h",
                             q[i].tag, q[i].field, cyc, act, q[i].val);
                end
            end else if (q[i].due > cyc) begin
                keep_q.push_back(q[i]);
            end
        end
        q = keep_q;
    end

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic expect_at(int dly, int field, logic [15:0] v, string tag);
        exp_t e;
        e.due = cyc + dly; e.field = field; e.val = v; e.tag = tag;
        q.push_back(e);
    endtask

    task automatic wr(logic [15:0] addr, logic [15:0] data);
        bus_addr = addr; bus_wdata = data; bus_we = 1'b1;
        step();
        bus_we = 1'b0;
    endtask

    task automatic rd_check(logic [15:0] addr, logic [15:0] v, string tag);
        bus_addr = addr;
        expect_at(0, F_RD, v, tag);
        step();
    endtask

    task automatic tick_run(bit use_aux, int n);
        if (use_aux) aux_tick = 1'b1; else sub_tick = 1'b1;
        repeat (n) step();
        aux_tick = 1'b0; sub_tick = 1'b0;
    endtask

    task automatic do_reset();
        rst = 1'b1;
        step();
        rst = 1'b0;
        expect_at(0, F_RST, 16'd0, "R10 rst_req cleared");
        rd_check(A_CTL, 16'h6900, "R10 control cleared");
    endtask

    initial begin
        repeat (3) step();
        rst = 1'b0;
        expect_at(0, F_RST, 16'd0, "R10 reset state rst_req");
        expect_at(0, F_IVL, 16'd0, "R10 reset state ivl");
        rd_check(A_CTL, 16'h6900, "R10 reset readback");

        // R3 and R2: clear bit dropped on store; valid key gives no reset
        wr(A_CTL, 16'h5A9B);
        expect_at(0, F_RST, 16'd0, "R1 valid key no reset");
        rd_check(A_CTL, 16'h6993, "R3 clear bit reads 0 / R2 readback");

        // R4: hold blocks counting
        for (int d = 1; d <= 100; d++) expect_at(d, F_IVL, 16'd0, "R4 hold");
        expect_at(100, F_RST, 16'd0, "R4 hold no reset");
        tick_run(0, 100);

        // R6/R7: interval mode, terminal 64, continuous wrap
        wr(A_CTL, 16'h5A1B);
        expect_at(63, F_IVL, 16'd0, "R6 tc64 early");
        expect_at(64, F_IVL, 16'd1, "R6 tc64 expiry");
        expect_at(65, F_IVL, 16'd0, "R7 pulse one cycle");
        expect_at(128, F_IVL, 16'd1, "R6 wrap second expiry");
        expect_at(128, F_RST, 16'd0, "R7 interval no reset");
        tick_run(0, 130);

        // R5: aux selected, sub ticks ignored
        wr(A_CTL, 16'h5A1F);
        expect_at(50, F_IVL, 16'd0, "R5 sub ignored");
        expect_at(100, F_IVL, 16'd0, "R5 sub ignored");
        tick_run(0, 100);
        expect_at(63, F_IVL, 16'd0, "R5 aux early");
        expect_at(64, F_IVL, 16'd1, "R5 aux expiry");
        tick_run(1, 64);

        // R3: clear mid-count restarts the interval
        wr(A_CTL, 16'h5A1B);
        tick_run(0, 40);
        wr(A_CTL, 16'h5A1B);
        expect_at(24, F_IVL, 16'd0, "R3 cleared no early expiry");
        expect_at(63, F_IVL, 16'd0, "R3 cleared early");
        expect_at(64, F_IVL, 16'd1, "R3 full interval after clear");
        tick_run(0, 64);

        // R6: 512 and 8192
        wr(A_CTL, 16'h5A1A);
        expect_at(511, F_IVL, 16'd0, "R6 tc512 early");
        expect_at(512, F_IVL, 16'd1, "R6 tc512 expiry");
        tick_run(0, 512);
        wr(A_CTL, 16'h5A19);
        expect_at(8191, F_IVL, 16'd0, "R6 tc8192 early");
        expect_at(8192, F_IVL, 16'd1, "R6 tc8192 expiry");
        tick_run(0, 8192);

        // R6: shortening interval keeps count modulo new terminal
        wr(A_CTL, 16'h5A1A);
        tick_run(0, 100);
        wr(A_CTL, 16'h5A13);
        expect_at(1, F_IVL, 16'd1, "R6 shortened immediate expiry");
        expect_at(27, F_IVL, 16'd0, "R6 carried count early");
        expect_at(28, F_IVL, 16'd1, "R6 carried count expiry");
        tick_run(0, 28);

        // R7/R11: watchdog expiry latches reset
        wr(A_CTL, 16'h5A0B);
        expect_at(63, F_RST, 16'd0, "R7 watchdog early");
        expect_at(64, F_RST, 16'd1, "R7 watchdog reset");
        expect_at(64, F_IVL, 16'd0, "R7 watchdog no ivl");
        tick_run(0, 64);
        wr(A_CTL, 16'h5A80);
        expect_at(0, F_RST, 16'd1, "R11 latched after valid write");
        expect_at(5, F_RST, 16'd1, "R11 latched held");
        repeat (6) step();
        do_reset();

        // R1: bad key
        wr(A_CTL, 16'h1234);
        expect_at(0, F_RST, 16'd1, "R1 bad key reset");
        rd_check(A_CTL, 16'h6934, "R1 low byte stored");
        do_reset();

        // R2: other address ignored
        wr(16'h0122, 16'h5A93);
        wr(16'h0122, 16'h0000);
        expect_at(0, F_RST, 16'd0, "R2 other address no reset");
        rd_check(16'h0122, 16'h0000, "R2 other address reads 0");
        rd_check(A_CTL, 16'h6900, "R2 control unchanged");

        // R10: default after reset is watchdog with 32768
        expect_at(32767, F_RST, 16'd0, "R10 default early");
        expect_at(32768, F_RST, 16'd1, "R10 default watchdog expiry");
        tick_run(0, 32768);
        do_reset();

        // R8: pin as reset input
        ext_pin = 1'b0;
        expect_at(1, F_RST, 16'd0, "R8 sync delay");
        expect_at(2, F_RST, 16'd1, "R8 pin low reset");
        repeat (5) step();
        ext_pin = 1'b1;
        expect_at(1, F_RST, 16'd1, "R8 pin still seen low");
        expect_at(2, F_RST, 16'd0, "R8 pin release not latched");
        repeat (4) step();

        // R9: NMI mode, falling edge selected
        wr(A_CTL, 16'h5A60);
        ext_pin = 1'b0;
        expect_at(2, F_NMI, 16'd0, "R9 nmi early");
        expect_at(3, F_NMI, 16'd1, "R9 falling edge nmi");
        expect_at(4, F_NMI, 16'd0, "R9 nmi one cycle");
        expect_at(3, F_RST, 16'd0, "R9 pin low no reset in nmi mode");
        repeat (6) step();
        ext_pin = 1'b1;
        expect_at(3, F_NMI, 16'd0, "R9 rising ignored when falling selected");
        repeat (6) step();
        wr(A_CTL, 16'h5A20);
        ext_pin = 1'b0;
        expect_at(3, F_NMI, 16'd0, "R9 falling ignored when rising selected");
        repeat (6) step();
        ext_pin = 1'b1;
        expect_at(3, F_NMI, 16'd1, "R9 rising edge nmi");
        repeat (6) step();

        repeat (3) step();
        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule